// File: doc/BRIEF.md
# I2C Register-Write Slave with High-Speed Mode Tracking

This block is the receive front end of an I2C target that accepts register writes. It samples SCL and SDA with a fast system clock and finds START, repeated START and STOP conditions. It matches a fixed 7-bit target address and then takes in a command byte followed by two data bytes. Each accepted byte is acknowledged by pulling SDA low for one SCL period. When the second data byte has been acknowledged, the block issues a one-cycle write strobe. The strobe carries a 7-bit register index and a 16-bit value.

The block also keeps a speed flag. A master code, sent in place of an address, arms the flag. The flag goes high at the repeated START that follows. Later repeated STARTs leave it set, and only a STOP clears it. The read path, pad timing and the register storage sit outside this block. `sda_oe` is a pull-down enable: the pad logic drives SDA low while it is 1.

Top module: `i2c_regwr_slave`

## Requirements
- R1: After reset, `sda_oe`, `wr_stb` and `hs_mode` are all 0.
- R2: A START followed by the matching 7-bit address (sent MSB first) with bit 0 = 0 is acknowledged. `sda_oe` is held high across exactly the ninth SCL pulse and released after that pulse's falling edge.
- R3: An address byte that does not match is not acknowledged. All following bytes up to the next START are ignored: they get no acknowledge and produce no strobe.
- R4: A command byte with bit 7 = 0 is acknowledged and its bits 6..0 become the register index. A command byte with bit 7 = 1 is not acknowledged and the cycle is dropped without a strobe.
- R5: Each of the two data bytes is acknowledged. After the second byte's acknowledge pulse, `wr_stb` is high for exactly one clock, with `wr_idx` = command[6:0] and `wr_val` = {first byte, second byte}.
- R6: Bytes sent after the second data byte are not acknowledged and produce no further strobe.
- R7: A START or a STOP that arrives before the second data byte's acknowledge is complete aborts the transfer with no strobe. A START also begins a new address phase.
- R8: An address byte of the form 8'b00001xxx is a master code. It is not acknowledged, and `hs_mode` stays 0 until the next repeated START, where `hs_mode` becomes 1.
- R9: A repeated START leaves `hs_mode` unchanged, and a STOP clears it to 0.
- R10: The matching address with bit 0 = 1 (a read request) is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level, as seen on the bus |
| sda_oe | output | 1 | 1 = pull SDA low (acknowledge) |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_idx | output | 7 | Register index for the write |
| wr_val | output | 16 | Register value for the write |
| hs_mode | output | 1 | 1 = high-speed mode, 0 = full/standard speed |

## Verification
A wrong internal state shows up at the ports within one byte time. A phase counter that is off, or a state that is wrong, moves or suppresses the acknowledge, and the master sees this at the ninth SCL pulse of the byte concerned. A mis-assembled byte order or index is visible in `wr_val` and `wr_idx` at the strobe, about four system clocks after the final acknowledge pulse ends. A speed flag that is stuck, or armed at the wrong time, shows on `hs_mode` within a few clocks of the next START or STOP.

// File: rtl/i2c_regwr_pkg.sv
package i2c_regwr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_HI,
    ST_LO,
    ST_ACK,
    ST_MCODE,
    ST_DONE
  } rx_state_e;

  localparam logic [4:0] MCODE_PREFIX = 5'b00001;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_lvl,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0][STAGES-1:0] chain;
  logic [LINES-1:0]             raw;
  logic [LINES-1:0]             lvl;
  logic [LINES-1:0]             prv;

  assign raw = {scl_i, sda_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prv   <= '1;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        chain[i] <= {chain[i][STAGES-2:0], raw[i]};
      end
      prv <= lvl;
    end
  end

  always_comb begin
    for (int i = 0; i < LINES; i++) lvl[i] = chain[i][STAGES-1];
  end

  // index 1 = SCL, index 0 = SDA
  assign scl_rise  = lvl[1] & ~prv[1];
  assign scl_fall  = ~lvl[1] & prv[1];
  assign sda_lvl   = lvl[0];
  assign start_det = lvl[1] & prv[1] & prv[0] & ~lvl[0];
  assign stop_det  = lvl[1] & prv[1] & ~prv[0] & lvl[0];
endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
  import i2c_regwr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h35,
  parameter int         IDX_W    = 7,
  parameter int         VAL_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_lvl,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_oe,
  output logic             wr_stb,
  output logic [IDX_W-1:0] wr_idx,
  output logic [VAL_W-1:0] wr_val,
  output logic             hs_mode
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  rx_state_e st, st_n, ret, ret_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [BYTE_W-1:0] sh, sh_n, hi, hi_n;
  logic [IDX_W-1:0]  idx, idx_n, widx_n;
  logic [VAL_W-1:0]  wval_n;
  logic              ackr, ackr_n, stb_n, hs_n;

  always_comb begin
    st_n   = st;
    ret_n  = ret;
    cnt_n  = cnt;
    sh_n   = sh;
    hi_n   = hi;
    idx_n  = idx;
    ackr_n = ackr;
    stb_n  = 1'b0;
    widx_n = wr_idx;
    wval_n = wr_val;
    hs_n   = hs_mode;
    if (stop_det) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
      hs_n  = 1'b0;
    end else if (start_det) begin
      if (st == ST_MCODE) hs_n = 1'b1;
      st_n   = ST_ADDR;
      cnt_n  = '0;
      ackr_n = 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_CMD, ST_HI, ST_LO, ST_DONE: begin
          if (scl_rise && cnt != FULL) begin
            sh_n  = {sh[BYTE_W-2:0], sda_lvl};
            cnt_n = cnt + 1'b1;
          end else if (scl_fall && cnt == FULL) begin
            cnt_n = '0;
            st_n  = ST_IDLE;
            case (st)
              ST_ADDR: begin
                if (sh[7:3] == MCODE_PREFIX) begin
                  st_n = ST_MCODE;
                end else if (sh[7:1] == DEV_ADDR && !sh[0]) begin
                  st_n  = ST_ACK;
                  ret_n = ST_CMD;
                end
              end
              ST_CMD: begin
                if (!sh[7]) begin
                  idx_n = sh[IDX_W-1:0];
                  st_n  = ST_ACK;
                  ret_n = ST_HI;
                end
              end
              ST_HI: begin
                hi_n  = sh;
                st_n  = ST_ACK;
                ret_n = ST_LO;
              end
              ST_LO: begin
                st_n  = ST_ACK;
                ret_n = ST_DONE;
              end
              default: st_n = ST_DONE;
            endcase
          end
        end
        ST_ACK: begin
          if (scl_rise) ackr_n = 1'b1;
          if (scl_fall && ackr) begin
            ackr_n = 1'b0;
            st_n   = ret;
            if (ret == ST_DONE) begin
              stb_n  = 1'b1;
              widx_n = idx;
              wval_n = {hi, sh};
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ret     <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      hi      <= '0;
      idx     <= '0;
      ackr    <= 1'b0;
      wr_stb  <= 1'b0;
      wr_idx  <= '0;
      wr_val  <= '0;
      hs_mode <= 1'b0;
    end else begin
      st      <= st_n;
      ret     <= ret_n;
      cnt     <= cnt_n;
      sh      <= sh_n;
      hi      <= hi_n;
      idx     <= idx_n;
      ackr    <= ackr_n;
      wr_stb  <= stb_n;
      wr_idx  <= widx_n;
      wr_val  <= wval_n;
      hs_mode <= hs_n;
    end
  end

  assign sda_oe = (st == ST_ACK);

  assert_ack_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(cnt) == FULL);
  assert_stb_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  assert_stb_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(st) == ST_ACK);
  assert_abort_no_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !wr_stb);
  assert_hs_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode) |-> $past(st) == ST_MCODE);
  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !hs_mode);
endmodule

// File: rtl/i2c_regwr_slave.sv
module i2c_regwr_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h35,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  output logic        wr_stb,
  output logic [6:0]  wr_idx,
  output logic [15:0] wr_val,
  output logic        hs_mode
);
  logic scl_rise, scl_fall, sda_lvl, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_lvl   (sda_lvl),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_wr_fsm #(.DEV_ADDR(DEV_ADDR), .IDX_W(7), .VAL_W(16)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_lvl   (sda_lvl),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .wr_stb    (wr_stb),
    .wr_idx    (wr_idx),
    .wr_val    (wr_val),
    .hs_mode   (hs_mode)
  );
endmodule

// File: tb/i2c_regwr_slave_test.sv
module i2c_regwr_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'h35;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, wr_stb, hs_mode;
  logic [6:0] wr_idx;
  logic [15:0] wr_val;
  logic sda_bus;

  int checks = 0;
  int errors = 0;
  int stb_cnt = 0;
  logic [6:0] last_idx;
  logic [15:0] last_val;
  bit done = 0;

  assign sda_bus = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_regwr_slave #(.DEV_ADDR(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_val(wr_val),
    .hs_mode(hs_mode)
  );

  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      stb_cnt++;
      last_idx = wr_idx;
      last_val = wr_val;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq();
    scl_m = 1'b1; wq(2 * Q);
    scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack, output bit rel);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    ack = ~sda_bus;
    wq();
    scl_m = 1'b0; wq();
    rel = ~sda_oe;
  endtask

  task automatic t_reset();
    wq(4);
    chk(sda_oe == 0, "R1 sda_oe", sda_oe, 0);
    chk(wr_stb == 0, "R1 wr_stb", wr_stb, 0);
    chk(hs_mode == 0, "R1 hs_mode", hs_mode, 0);
  endtask

  task automatic do_write(input logic [6:0] idx, input logic [15:0] val, input string tag);
    bit a, r;
    int n0 = stb_cnt;
    send_byte({DEV, 1'b0}, a, r);
    chk(a, {"R2 addr ack ", tag}, a, 1);
    chk(r, {"R2 ack release ", tag}, r, 1);
    send_byte({1'b0, idx}, a, r);
    chk(a, {"R4 cmd ack ", tag}, a, 1);
    send_byte(val[15:8], a, r);
    chk(a, {"R5 hi ack ", tag}, a, 1);
    send_byte(val[7:0], a, r);
    chk(a, {"R5 lo ack ", tag}, a, 1);
    wq(2);
    chk(stb_cnt == n0 + 1, {"R5 strobe count ", tag}, stb_cnt - n0, 1);
    chk(last_idx == idx, {"R5 idx ", tag}, last_idx, idx);
    chk(last_val == val, {"R5 val ", tag}, last_val, val);
  endtask

  task automatic t_write_basic();
    i2c_start();
    do_write(7'h12, 16'hA55A, "w1");
    i2c_stop();
    i2c_start();
    do_write(7'h7F, 16'h00FF, "w2");
    i2c_stop();
    wq(4);
    chk(hs_mode == 0, "R9 hs stays low", hs_mode, 0);
  endtask

  task automatic t_bad_addr();
    bit a, r;
    int n0 = stb_cnt;
    i2c_start();
    send_byte({7'h36, 1'b0}, a, r);
    chk(!a, "R3 wrong addr nack", a, 0);
    send_byte(8'h05, a, r);
    chk(!a, "R3 follow byte ignored", a, 0);
    send_byte(8'h11, a, r);
    send_byte(8'h22, a, r);
    i2c_stop();
    wq(4);
    chk(stb_cnt == n0, "R3 no strobe", stb_cnt - n0, 0);
  endtask

  task automatic t_read_bit();
    bit a, r;
    i2c_start();
    send_byte({DEV, 1'b1}, a, r);
    chk(!a, "R10 read request nack", a, 0);
    i2c_stop();
  endtask

  task automatic t_cmd_read();
    bit a, r;
    int n0 = stb_cnt;
    i2c_start();
    send_byte({DEV, 1'b0}, a, r);
    send_byte(8'h85, a, r);
    chk(!a, "R4 cmd msb1 nack", a, 0);
    send_byte(8'h11, a, r);
    chk(!a, "R4 data after bad cmd", a, 0);
    send_byte(8'h22, a, r);
    i2c_stop();
    wq(4);
    chk(stb_cnt == n0, "R4 no strobe", stb_cnt - n0, 0);
  endtask

  task automatic t_extra_byte();
    bit a, r;
    int n0 = stb_cnt;
    i2c_start();
    do_write(7'h03, 16'h1234, "x");
    send_byte(8'hEE, a, r);
    chk(!a, "R6 extra byte nack", a, 0);
    i2c_stop();
    wq(4);
    chk(stb_cnt == n0 + 1, "R6 single strobe", stb_cnt - n0, 1);
    chk(last_val == 16'h1234, "R6 value kept", last_val, 16'h1234);
  endtask

  task automatic t_abort();
    bit a, r;
    int n0 = stb_cnt;
    i2c_start();
    send_byte({DEV, 1'b0}, a, r);
    send_byte(8'h44, a, r);
    send_byte(8'hC3, a, r);
    for (int i = 0; i < 4; i++) send_bit(i[0]);
    i2c_start();
    wq(2);
    chk(stb_cnt == n0, "R7 Sr abort no strobe", stb_cnt - n0, 0);
    do_write(7'h21, 16'hBEEF, "after Sr");
    i2c_stop();
    n0 = stb_cnt;
    i2c_start();
    send_byte({DEV, 1'b0}, a, r);
    send_byte(8'h10, a, r);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    i2c_stop();
    wq(4);
    chk(stb_cnt == n0, "R7 stop abort no strobe", stb_cnt - n0, 0);
  endtask

  task automatic t_hs();
    bit a, r;
    i2c_start();
    send_byte(8'h0B, a, r);
    chk(!a, "R8 master code nack", a, 0);
    wq(2);
    chk(hs_mode == 0, "R8 hs low before Sr", hs_mode, 0);
    i2c_start();
    wq(2);
    chk(hs_mode == 1, "R8 hs set at Sr", hs_mode, 1);
    do_write(7'h2C, 16'h5AA5, "hs1");
    i2c_start();
    wq(2);
    chk(hs_mode == 1, "R9 Sr keeps hs", hs_mode, 1);
    do_write(7'h2D, 16'hC001, "hs2");
    i2c_stop();
    wq(4);
    chk(hs_mode == 0, "R9 stop clears hs", hs_mode, 0);
  endtask

  initial begin
    wq(3);
    rst_n = 1'b1;
    t_reset();
    t_write_basic();
    t_bad_addr();
    t_read_bit();
    t_cmd_read();
    t_extra_byte();
    t_abort();
    t_hs();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule